// File: doc/BRIEF.md
# Concurrent-Write Conflict Resolver

This block sits in front of one shared memory word that several processor ports may write in the same cycle. Each port presents a request bit and a data value. The block settles the conflict under one of four policies, chosen by a configuration input that is sampled every cycle:

- **Common** writes only when all requesters agree on the value.
- **Arbitrary** lets one requester through, chosen by a rotating pointer.
- **Priority** lets the lowest-numbered requester through.
- **Reduce** combines all requested values with a selectable associative operator.

Each cycle the block produces at most one committed write (enable and data) and a per-port grant or fail status. These outputs are registered and appear one cycle after the requests.

Address decoding, reads and the memory array belong to the surrounding logic. All requests in a cycle are taken to target the same word.

Top module: `cw_resolver`

## Requirements
- R1: Under reset, and in the cycle after a cycle with no requests, `wr_en_o`, `grant_o`, `fail_o`, `overflow_o` and `wr_data_o` are all zero.
- R2: All outputs appear one clock after the requests they answer. In that result every requesting port has exactly one of its `grant_o` or `fail_o` bits set, and non-requesting ports have neither.
- R3: In every policy, a cycle with exactly one requester writes that port's value and grants that port.
- R4: Common (`policy_i`=0): if all requesters present the same value, that value is written and all of them are granted. Otherwise `wr_en_o` stays low and every requester is failed.
- R5: Arbitrary (`policy_i`=1): exactly one requester is granted and the others fail.
  - A pointer, reset to 0, gives the starting port. The first requesting port at or cyclically after the pointer wins.
  - The pointer then moves to the winner plus one, modulo the port count.
  - The pointer changes only on Arbitrary cycles that have requests.
- R6: Priority (`policy_i`=2): the requester with the lowest port index is granted and all other requesters fail.
- R7: Reduce (`policy_i`=3): all requesters are granted and the written value is the reduction of their values under `red_op_i`.
  - 0 = add modulo 2^DATA_W
  - 1 = AND
  - 2 = OR
  - 3 = XOR
  - 4 = unsigned maximum
  - 5 to 7 act as add
- R8: `overflow_o` is high only for a Reduce cycle with the add operator whose true sum is 2^DATA_W or more. The written value is then the wrapped sum.
- R9: `wr_data_o` is zero whenever `wr_en_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| policy_i | input | 2 | Conflict policy: 0 common, 1 arbitrary, 2 priority, 3 reduce |
| red_op_i | input | 3 | Reduce operator: 0 add, 1 AND, 2 OR, 3 XOR, 4 max, others add |
| req_valid_i | input | NUM_PORTS | Per-port write request |
| req_data_i | input | NUM_PORTS*DATA_W | Per-port write value, port k at bits k*DATA_W upward |
| wr_en_o | output | 1 | Committed write enable |
| wr_data_o | output | DATA_W | Committed write value |
| grant_o | output | NUM_PORTS | Per-port success |
| fail_o | output | NUM_PORTS | Per-port failure |
| overflow_o | output | 1 | Sum exceeded DATA_W bits |

## Verification
The resolver is driven with the following request patterns:

- **Single requester, in each policy.** This shows that arbitration never blocks a lone writer.
- **Matching and mismatching value sets under Common.** These separate the agreement check from a plain OR of the requests.
- **Repeated all-port requests under Arbitrary, with Priority cycles in between.** This shows the pointer rotating and staying put when the policy is not Arbitrary.
- **Sparse masks under Priority.** These show that the lowest index wins rather than a fixed port.

Reduce cycles use value sets whose sum wraps and sets in which a large value sits on a non-requesting port. Together these separate each operator, the overflow flag, and the masking of idle ports.

// File: rtl/cw_resolver_pkg.sv
package cw_resolver_pkg;
  typedef enum logic [1:0] {
    POL_COMMON    = 2'd0,
    POL_ARBITRARY = 2'd1,
    POL_PRIORITY  = 2'd2,
    POL_REDUCE    = 2'd3
  } policy_e;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_AND = 3'd1,
    OP_OR  = 3'd2,
    OP_XOR = 3'd3,
    OP_MAX = 3'd4
  } red_op_e;
endpackage

// File: rtl/cw_pick.sv
// First requesting port at or cyclically after start_i.
module cw_pick #(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned IDX_W     = 2
) (
  input  logic [NUM_PORTS-1:0] valid_i,
  input  logic [IDX_W-1:0]     start_i,
  output logic                 found_o,
  output logic [IDX_W-1:0]     idx_o
);
  always_comb begin : pick_c
    int j;
    found_o = 1'b0;
    idx_o   = '0;
    for (int k = 0; k < int'(NUM_PORTS); k++) begin
      j = int'(start_i) + k;
      if (j >= int'(NUM_PORTS)) j = j - int'(NUM_PORTS);
      if (!found_o && valid_i[j]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(j);
      end
    end
  end
endmodule

// File: rtl/cw_agree.sv
// Checks that every requesting port carries the same value.
module cw_agree #(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned DATA_W    = 8
) (
  input  logic [NUM_PORTS-1:0]        valid_i,
  input  logic [NUM_PORTS*DATA_W-1:0] data_i,
  output logic                        agree_o,
  output logic [DATA_W-1:0]           value_o
);
  logic [DATA_W-1:0] port_data [NUM_PORTS];

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_unpack
    assign port_data[g] = data_i[g*DATA_W +: DATA_W];
  end

  always_comb begin : agree_c
    logic have;
    have    = 1'b0;
    agree_o = 1'b1;
    value_o = '0;
    for (int i = 0; i < int'(NUM_PORTS); i++) begin
      if (valid_i[i]) begin
        if (!have) begin
          have    = 1'b1;
          value_o = port_data[i];
        end else if (port_data[i] != value_o) begin
          agree_o = 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/cw_reduce.sv
// Associative reduction over the requesting ports.
module cw_reduce
  import cw_resolver_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned SUM_W     = 10
) (
  input  logic [NUM_PORTS-1:0]        valid_i,
  input  logic [NUM_PORTS*DATA_W-1:0] data_i,
  input  logic [2:0]                  op_i,
  output logic [DATA_W-1:0]           result_o,
  output logic                        carry_o
);
  logic [DATA_W-1:0] port_data [NUM_PORTS];
  logic [SUM_W-1:0]  sum;
  logic [DATA_W-1:0] and_v, or_v, xor_v, max_v;
  red_op_e           op;

  assign op = red_op_e'(op_i);

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_unpack
    assign port_data[g] = data_i[g*DATA_W +: DATA_W];
  end

  always_comb begin
    sum   = '0;
    and_v = '1;
    or_v  = '0;
    xor_v = '0;
    max_v = '0;
    for (int i = 0; i < int'(NUM_PORTS); i++) begin
      if (valid_i[i]) begin
        sum   = sum + SUM_W'(port_data[i]);
        and_v = and_v & port_data[i];
        or_v  = or_v | port_data[i];
        xor_v = xor_v ^ port_data[i];
        if (port_data[i] > max_v) max_v = port_data[i];
      end
    end
  end

  always_comb begin
    carry_o = 1'b0;
    unique case (op)
      OP_AND:  result_o = and_v;
      OP_OR:   result_o = or_v;
      OP_XOR:  result_o = xor_v;
      OP_MAX:  result_o = max_v;
      default: begin
        result_o = sum[DATA_W-1:0];
        carry_o  = |sum[SUM_W-1:DATA_W];
      end
    endcase
  end
endmodule

// File: rtl/cw_resolver.sv
module cw_resolver
  import cw_resolver_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned DATA_W    = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [1:0]                  policy_i,
  input  logic [2:0]                  red_op_i,
  input  logic [NUM_PORTS-1:0]        req_valid_i,
  input  logic [NUM_PORTS*DATA_W-1:0] req_data_i,
  output logic                        wr_en_o,
  output logic [DATA_W-1:0]           wr_data_o,
  output logic [NUM_PORTS-1:0]        grant_o,
  output logic [NUM_PORTS-1:0]        fail_o,
  output logic                        overflow_o
);
  localparam int unsigned IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
  localparam int unsigned SUM_W = DATA_W + IDX_W;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PORTS - 1);

  policy_e             pol;
  logic [IDX_W-1:0]    rr_ptr_q;
  logic                rr_found, pr_found;
  logic [IDX_W-1:0]    rr_idx, pr_idx;
  logic                agree;
  logic [DATA_W-1:0]   agree_val;
  logic [DATA_W-1:0]   red_val;
  logic                red_carry;

  logic                wr_en_d, ovf_d;
  logic [DATA_W-1:0]   data_d;
  logic [NUM_PORTS-1:0] grant_d, fail_d;

  assign pol = policy_e'(policy_i);

  cw_pick #(.NUM_PORTS(NUM_PORTS), .IDX_W(IDX_W)) u_rr_pick (
    .valid_i (req_valid_i),
    .start_i (rr_ptr_q),
    .found_o (rr_found),
    .idx_o   (rr_idx)
  );

  cw_pick #(.NUM_PORTS(NUM_PORTS), .IDX_W(IDX_W)) u_pr_pick (
    .valid_i (req_valid_i),
    .start_i ('0),
    .found_o (pr_found),
    .idx_o   (pr_idx)
  );

  cw_agree #(.NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W)) u_agree (
    .valid_i (req_valid_i),
    .data_i  (req_data_i),
    .agree_o (agree),
    .value_o (agree_val)
  );

  cw_reduce #(.NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W), .SUM_W(SUM_W)) u_reduce (
    .valid_i  (req_valid_i),
    .data_i   (req_data_i),
    .op_i     (red_op_i),
    .result_o (red_val),
    .carry_o  (red_carry)
  );

  always_comb begin
    wr_en_d = 1'b0;
    data_d  = '0;
    grant_d = '0;
    fail_d  = '0;
    ovf_d   = 1'b0;
    if (|req_valid_i) begin
      unique case (pol)
        POL_COMMON: begin
          if (agree) begin
            wr_en_d = 1'b1;
            data_d  = agree_val;
            grant_d = req_valid_i;
          end else begin
            fail_d  = req_valid_i;
          end
        end
        POL_ARBITRARY: begin
          wr_en_d = rr_found;
          data_d  = req_data_i[rr_idx*DATA_W +: DATA_W];
          grant_d = NUM_PORTS'(1) << rr_idx;
          fail_d  = req_valid_i & ~grant_d;
        end
        POL_PRIORITY: begin
          wr_en_d = pr_found;
          data_d  = req_data_i[pr_idx*DATA_W +: DATA_W];
          grant_d = NUM_PORTS'(1) << pr_idx;
          fail_d  = req_valid_i & ~grant_d;
        end
        default: begin
          wr_en_d = 1'b1;
          data_d  = red_val;
          grant_d = req_valid_i;
          ovf_d   = red_carry;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rr_ptr_q   <= '0;
      wr_en_o    <= 1'b0;
      wr_data_o  <= '0;
      grant_o    <= '0;
      fail_o     <= '0;
      overflow_o <= 1'b0;
    end else begin
      if (pol == POL_ARBITRARY && rr_found)
        rr_ptr_q <= (rr_idx == LAST_IDX) ? '0 : rr_idx + IDX_W'(1);
      wr_en_o    <= wr_en_d;
      wr_data_o  <= data_d;
      grant_o    <= grant_d;
      fail_o     <= fail_d;
      overflow_o <= ovf_d;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|req_valid_i) |=> (!wr_en_o && grant_o == '0 && fail_o == '0 && !overflow_o)); // R1
  AST_STATUS_COVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((grant_o | fail_o) == $past(req_valid_i) && (grant_o & fail_o) == '0)); // R2
  AST_SOLO_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(req_valid_i) |=> (wr_en_o && grant_o == $past(req_valid_i))); // R3
  AST_COMMON_MISMATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pol == POL_COMMON && |req_valid_i && !agree) |=> (!wr_en_o && fail_o == $past(req_valid_i))); // R4
  AST_ARB_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pol == POL_ARBITRARY && |req_valid_i) |=> ($countones(grant_o) == 1 && wr_en_o)); // R5
  AST_PRIO_LOWEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pol == POL_PRIORITY && |req_valid_i) |=>
      (grant_o == ($past(req_valid_i) & (~$past(req_valid_i) + NUM_PORTS'(1))))); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pol == POL_REDUCE && (red_op_i == 3'd0 || red_op_i > 3'd4)) |=> !overflow_o); // R8
  AST_ZERO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_o |-> wr_data_o == '0); // R9
endmodule

// File: tb/cw_resolver_tb_top.sv
module cw_resolver_tb_top;
  localparam int P = 4;
  localparam int W = 8;

  logic             clk;
  logic             rst_n;
  logic [1:0]       policy;
  logic [2:0]       red_op;
  logic [P-1:0]     req_valid;
  logic [P*W-1:0]   req_data;
  logic             wr_en;
  logic [W-1:0]     wr_data;
  logic [P-1:0]     grant, fail;
  logic             ovf;

  typedef struct packed {
    logic         wr_en;
    logic [W-1:0] data;
    logic [P-1:0] grant;
    logic [P-1:0] fail;
    logic         ovf;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    checks = 0;
  int    errors = 0;
  int    bptr   = 0;
  bit    done   = 0;

  cw_resolver #(.NUM_PORTS(P), .DATA_W(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .policy_i(policy), .red_op_i(red_op),
    .req_valid_i(req_valid), .req_data_i(req_data),
    .wr_en_o(wr_en), .wr_data_o(wr_data), .grant_o(grant), .fail_o(fail),
    .overflow_o(ovf)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] pol, input logic [2:0] op, input logic [P-1:0] v,
                       input logic [W-1:0] d0, input logic [W-1:0] d1,
                       input logic [W-1:0] d2, input logic [W-1:0] d3, input string tag);
    logic [W-1:0] d[P];
    exp_t e;
    bit   have, same;
    int   sum;
    logic [W-1:0] a, o, x, m, first;
    d[0] = d0; d[1] = d1; d[2] = d2; d[3] = d3;
    @(negedge clk);
    policy = pol; red_op = op; req_valid = v; req_data = {d3, d2, d1, d0};
    e = '0;
    if (v != 0) begin
      case (pol)
        2'd0: begin
          have = 0; same = 1; first = '0;
          for (int i = 0; i < P; i++)
            if (v[i]) begin
              if (!have) begin have = 1; first = d[i]; end
              else if (d[i] != first) same = 0;
            end
          if (same) begin e.wr_en = 1; e.data = first; e.grant = v; end
          else e.fail = v;
        end
        2'd1: begin
          have = 0;
          for (int k = 0; k < P; k++) begin
            int j;
            j = (bptr + k) % P;
            if (!have && v[j]) begin
              have = 1; e.wr_en = 1; e.data = d[j]; e.grant = P'(1) << j;
              bptr = (j + 1) % P;
            end
          end
          e.fail = v & ~e.grant;
        end
        2'd2: begin
          have = 0;
          for (int i = 0; i < P; i++)
            if (!have && v[i]) begin
              have = 1; e.wr_en = 1; e.data = d[i]; e.grant = P'(1) << i;
            end
          e.fail = v & ~e.grant;
        end
        default: begin
          sum = 0; a = '1; o = '0; x = '0; m = '0;
          for (int i = 0; i < P; i++)
            if (v[i]) begin
              sum += int'(d[i]); a &= d[i]; o |= d[i]; x ^= d[i];
              if (d[i] > m) m = d[i];
            end
          e.wr_en = 1; e.grant = v;
          case (op)
            3'd1: e.data = a;
            3'd2: e.data = o;
            3'd3: e.data = x;
            3'd4: e.data = m;
            default: begin
              e.data = W'(sum);
              e.ovf  = (sum >= (1 << W));
            end
          endcase
        end
      endcase
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // Monitor: result of requests driven at a negedge appears after the next posedge.
  always @(posedge clk) begin
    exp_t  e;
    string t;
    #1;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      cmp(t, "wr_en", 32'(wr_en), 32'(e.wr_en));
      cmp(t, "wr_data", 32'(wr_data), 32'(e.data));
      cmp(t, "grant (R2 status)", 32'(grant), 32'(e.grant));
      cmp(t, "fail (R2 status)", 32'(fail), 32'(e.fail));
      cmp(t, "overflow", 32'(ovf), 32'(e.ovf));
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R2: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; policy = 0; red_op = 0; req_valid = 0; req_data = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    cmp("R1", "reset wr_en", 32'(wr_en), 0);
    cmp("R1", "reset grant", 32'(grant), 0);
    cmp("R1", "reset fail", 32'(fail), 0);
    cmp("R1", "reset data/ovf", 32'({wr_data, ovf}), 0);
    rst_n = 1;

    drive(2'd0, 3'd0, 4'b0000, 8'h11, 8'h22, 8'h33, 8'h44, "R1 idle");
    // R3: solo in each policy
    drive(2'd0, 3'd0, 4'b0100, 8'h00, 8'h00, 8'h3C, 8'h00, "R3 solo common");
    drive(2'd1, 3'd0, 4'b0100, 8'h00, 8'h00, 8'h3D, 8'h00, "R3 solo arbitrary");
    drive(2'd2, 3'd0, 4'b1000, 8'h00, 8'h00, 8'h00, 8'h3E, "R3 solo priority");
    drive(2'd3, 3'd0, 4'b0001, 8'hFF, 8'h00, 8'h00, 8'h00, "R3 R8 solo reduce add");
    // R4 common
    drive(2'd0, 3'd0, 4'b1011, 8'h5A, 8'h5A, 8'h00, 8'h5A, "R4 common agree");
    drive(2'd0, 3'd0, 4'b1011, 8'h5A, 8'h5A, 8'h5A, 8'h5B, "R4 R9 common disagree");
    drive(2'd0, 3'd0, 4'b0011, 8'h77, 8'h77, 8'h01, 8'h02, "R4 common agree masked");
    // R6 priority
    drive(2'd2, 3'd0, 4'b1110, 8'h10, 8'h21, 8'h32, 8'h43, "R6 priority");
    drive(2'd2, 3'd0, 4'b1010, 8'h10, 8'h21, 8'h32, 8'h43, "R6 priority sparse");
    // R5 arbitrary rotation
    for (int n = 0; n < 5; n++)
      drive(2'd1, 3'd0, 4'b1111, 8'hA0, 8'hA1, 8'hA2, 8'hA3, "R5 arbitrary rotate");
    drive(2'd2, 3'd0, 4'b1111, 8'hB0, 8'hB1, 8'hB2, 8'hB3, "R5 R6 priority keeps pointer");
    drive(2'd1, 3'd0, 4'b0101, 8'hC0, 8'hC1, 8'hC2, 8'hC3, "R5 arbitrary sparse");
    drive(2'd1, 3'd0, 4'b0101, 8'hC0, 8'hC1, 8'hC2, 8'hC3, "R5 arbitrary sparse skip");
    drive(2'd1, 3'd0, 4'b0101, 8'hC0, 8'hC1, 8'hC2, 8'hC3, "R5 arbitrary sparse wrap");
    // R7 / R8 reduce
    drive(2'd3, 3'd0, 4'b0111, 8'd10, 8'd20, 8'd30, 8'd99, "R7 reduce add");
    drive(2'd3, 3'd0, 4'b0011, 8'd200, 8'd100, 8'd0, 8'd0, "R8 reduce add overflow");
    drive(2'd3, 3'd0, 4'b1111, 8'hFF, 8'hFF, 8'hFF, 8'hFF, "R8 reduce add max overflow");
    drive(2'd3, 3'd1, 4'b1111, 8'hF0, 8'h3C, 8'hAA, 8'h0F, "R7 reduce and");
    drive(2'd3, 3'd1, 4'b0110, 8'h00, 8'hFC, 8'hBE, 8'h00, "R7 reduce and masked");
    drive(2'd3, 3'd2, 4'b1111, 8'hF0, 8'h3C, 8'hAA, 8'h0F, "R7 R8 reduce or no overflow");
    drive(2'd3, 3'd3, 4'b1101, 8'hF0, 8'h3C, 8'hAA, 8'h0F, "R7 reduce xor");
    drive(2'd3, 3'd4, 4'b0110, 8'hF0, 8'h3C, 8'hAA, 8'h0F, "R7 reduce max masked");
    drive(2'd3, 3'd6, 4'b1100, 8'h00, 8'h00, 8'h90, 8'h90, "R7 R8 reduce op6 as add");
    drive(2'd1, 3'd0, 4'b0000, 8'hFF, 8'hFF, 8'hFF, 8'hFF, "R1 R5 idle arbitrary");
    drive(2'd1, 3'd0, 4'b1111, 8'hD0, 8'hD1, 8'hD2, 8'hD3, "R5 pointer after idle");
    drive(2'd0, 3'd0, 4'b0000, 8'h00, 8'h00, 8'h00, 8'h00, "R1 R9 idle end");
    @(negedge clk);
    req_valid = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule